// File: doc/BRIEF.md
# Byte-Port Packet NIC Register Block

This block lets a host move Ethernet-sized frames in and out through a small register window. One frame buffer serves each direction. The host reads a received frame one byte per access from a data port. It builds an outgoing frame one byte per access at another port. It launches the frame by writing exactly as many bytes as it announced in a length register. A busy flag gates the receive side. An interrupt-control register with three sticky bits drives a level interrupt.

On the network side, received bytes arrive on a valid/ready/last byte stream. The block raises ready only while it can take a whole new frame. A frame that starts while ready is low is discarded up to its last beat. Transmitted frames leave on a second valid/ready/last stream. The interrupt-control register also carries a test bit. Writing that bit restores the block to its reset state and raises the interrupt, so software can check the interrupt path.

Top module: `nic_regport`

## Requirements
- R1: Only the low 6 bits of `reg_addr` select a register; higher address bits are ignored. Offsets are: 0x00 and 0x04 identification, 0x08 busy, 0x0C receive count, 0x10 transmit count, 0x14 interrupt control, 0x18 interrupt info, 0x1C receive data, 0x20 transmit data.
- R2: The identification offsets return the parameters `ID_WORD0` and `ID_WORD1`. Interrupt info, the transmit data port and unmapped offsets read as zero. Writes to identification, busy, receive count, interrupt info and receive data change nothing.
- R3: After reset, busy reads 1, both counts read 0, interrupt control reads 0 and `irq` is low.
- R4: Interrupt control bit 0 is transmit done, bit 1 is receive done and bit 31 is the test bit. `irq` is high exactly when any of them is set.
- R5: `rx_ready` is high between frames only when busy is 0 and the receive count is below `MAX_FRAME`. A frame whose first beat arrives while `rx_ready` is low is dropped whole and changes no register.
- R6: When an accepted frame's last beat is taken, the receive count becomes the frame length, capped at `MAX_FRAME`, with bytes beyond the cap discarded. The read pointer returns to the first byte, busy becomes 1 and receive done is set.
- R7: A read of the receive data port with a nonzero count returns the next frame byte in arrival order (bits 7:0) and decrements the count. With a zero count it returns 0 and changes nothing.
- R8: A read of interrupt control returns its value and then clears the test bit.
- R9: A write to the transmit count loads the value if it is at most `MAX_FRAME` and loads 0 otherwise. Either way the transmit write pointer returns to 0.
- R10: A write to interrupt control acts on bit 0 first (clear transmit done), else on bit 1 (clear receive done), else on bit 31 (self-test). After any such write, busy equals whether any interrupt-control bit is still set.
- R11: A self-test write clears both counts, both pointers and interrupt control, then sets the test bit, leaving busy at 1.
- R12: A transmit data write stores bits 7:0 and advances the write pointer. When the pointer reaches the transmit count, the frame leaves on `tx_data` in order, with `tx_last` on the final byte and data held while `tx_ready` is low. The transmit count then reads 0, transmit done is set and busy becomes 1.
- R13: Transmit data writes made while a frame is still leaving the stream are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register byte address |
| reg_rd | input | 1 | Read strobe, one access per cycle high |
| reg_wr | input | 1 | Write strobe; a cycle with both strobes is a write only |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 1 | Level interrupt |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of a receive frame |
| rx_ready | output | 1 | Block will take the receive beat |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of a transmit frame |
| tx_ready | input | 1 | Sink takes the transmit beat |

## Verification
The bench builds the block with `MAX_FRAME` = 16 and `ADDR_W` = 8. The small buffer puts both capacity limits within a few beats: oversize receive frames are truncated, and a transmit count just above the limit is rejected. The two spare address bits show that aliased offsets reach the same registers. Random frame lengths, contents and sink stalls run next to directed cases for the clear priority, the self-test write, and transmit writes made during a drain.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;

    // register offsets (low six address bits)
    localparam logic [5:0] OFF_ID0    = 6'h00;
    localparam logic [5:0] OFF_ID1    = 6'h04;
    localparam logic [5:0] OFF_BUSY   = 6'h08;
    localparam logic [5:0] OFF_RXCNT  = 6'h0C;
    localparam logic [5:0] OFF_TXCNT  = 6'h10;
    localparam logic [5:0] OFF_ICTL   = 6'h14;
    localparam logic [5:0] OFF_IINFO  = 6'h18;
    localparam logic [5:0] OFF_RXDATA = 6'h1C;
    localparam logic [5:0] OFF_TXDATA = 6'h20;

    // interrupt-control bit positions
    localparam int ICTL_TXD  = 0;
    localparam int ICTL_RXD  = 1;
    localparam int ICTL_TEST = 31;

    typedef struct packed {
        logic test;
        logic rxd;
        logic txd;
    } ictl_t;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_TAKE = 2'd1,
        RX_SKIP = 2'd2
    } rx_state_e;

    function automatic logic [31:0] ictl_word(ictl_t v);
        return {v.test, 29'd0, v.rxd, v.txd};
    endfunction

endpackage

// File: rtl/nic_rx_capture.sv
module nic_rx_capture
    import nic_regs_pkg::*;
#(
    parameter int MAX_FRAME = 1514
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               soft_rst,
    input  logic                               can_start,
    input  logic                               rx_valid,
    input  logic [7:0]                         rx_data,
    input  logic                               rx_last,
    output logic                               rx_ready,
    input  logic                               pop,
    output logic [7:0]                         pop_data,
    output logic [$clog2(MAX_FRAME+1)-1:0]     rx_count,
    output logic                               frame_done
);
    localparam int CNT_W = $clog2(MAX_FRAME + 1);
    localparam int IDX_W = $clog2(MAX_FRAME);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_FRAME);

    rx_state_e        state;
    logic [CNT_W-1:0] wlen, rptr, widx, new_len;
    logic [7:0]       mem [MAX_FRAME];
    logic             accept, beat, room;

    assign accept     = can_start && (rx_count < MAX_C);
    assign rx_ready   = ((state == RX_IDLE) && accept) || (state == RX_TAKE);
    assign beat       = rx_valid && rx_ready;
    assign widx       = (state == RX_TAKE) ? wlen : '0;
    assign room       = widx < MAX_C;
    assign new_len    = room ? widx + 1'b1 : MAX_C;
    assign frame_done = beat && rx_last && !soft_rst;
    assign pop_data   = (rx_count != '0) ? mem[rptr[IDX_W-1:0]] : 8'h00;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            state <= RX_IDLE;
            wlen  <= '0;
        end else begin
            case (state)
                RX_IDLE: if (rx_valid && !rx_last) begin
                    state <= accept ? RX_TAKE : RX_SKIP;
                    wlen  <= new_len;
                end
                RX_TAKE: if (rx_valid) begin
                    wlen <= new_len;
                    if (rx_last) state <= RX_IDLE;
                end
                RX_SKIP: if (rx_valid && rx_last) state <= RX_IDLE;
                default: state <= RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            rx_count <= '0;
            rptr     <= '0;
        end else if (frame_done) begin
            rx_count <= new_len;
            rptr     <= '0;
        end else if (pop && rx_count != '0) begin
            rx_count <= rx_count - 1'b1;
            rptr     <= rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (beat && room) mem[widx[IDX_W-1:0]] <= rx_data;
    end

    // R7
    rx_pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && rx_count != '0 && !frame_done && !soft_rst) |=> rx_count == $past(rx_count) - 1'b1);

    // R6
    rx_done_load_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> (rx_count != '0 && rx_count <= MAX_C));

endmodule

// File: rtl/nic_tx_path.sv
module nic_tx_path
    import nic_regs_pkg::*;
#(
    parameter int MAX_FRAME = 1514
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               soft_rst,
    input  logic                               cnt_wr,
    input  logic [31:0]                        cnt_val,
    input  logic                               dat_wr,
    input  logic [7:0]                         dat_byte,
    output logic [$clog2(MAX_FRAME+1)-1:0]     tx_count,
    output logic                               sent,
    output logic                               tx_valid,
    output logic [7:0]                         tx_data,
    output logic                               tx_last,
    input  logic                               tx_ready
);
    localparam int CNT_W = $clog2(MAX_FRAME + 1);
    localparam int IDX_W = $clog2(MAX_FRAME);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_FRAME);

    logic [CNT_W-1:0] wptr, didx, dlen;
    logic             draining, take;
    logic [7:0]       mem [MAX_FRAME];

    assign take     = dat_wr && !draining && (wptr < MAX_C);
    assign sent     = take && (wptr + 1'b1 == tx_count) && !soft_rst;
    assign tx_valid = draining;
    assign tx_last  = draining && (didx == dlen - 1'b1);
    assign tx_data  = draining ? mem[didx[IDX_W-1:0]] : 8'h00;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            tx_count <= '0;
            wptr     <= '0;
        end else if (cnt_wr) begin
            tx_count <= (cnt_val <= 32'(MAX_FRAME)) ? cnt_val[CNT_W-1:0] : '0;
            wptr     <= '0;
        end else if (sent) begin
            tx_count <= '0;
            wptr     <= '0;
        end else if (take) begin
            wptr <= wptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            draining <= 1'b0;
            didx     <= '0;
            dlen     <= '0;
        end else if (sent) begin
            draining <= 1'b1;
            didx     <= '0;
            dlen     <= tx_count;
        end else if (draining && tx_ready) begin
            if (tx_last) draining <= 1'b0;
            didx <= didx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (take) mem[wptr[IDX_W-1:0]] <= dat_byte;
    end

    // R9
    tx_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        tx_count <= MAX_C);

    // R12
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !soft_rst) |=> (tx_valid && $stable(tx_data)));

endmodule

// File: rtl/nic_regport.sv
module nic_regport
    import nic_regs_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          MAX_FRAME = 1514,
    parameter logic [31:0] ID_WORD0  = 32'h4E49_4330,
    parameter logic [31:0] ID_WORD1  = 32'h5042_5546
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready
);
    localparam int CNT_W = $clog2(MAX_FRAME + 1);

    logic [5:0]       off;
    logic             host_rd, host_wr, soft_rst, busy, busy_nx;
    logic             rx_done, tx_sent;
    logic [7:0]       pop_data;
    logic [CNT_W-1:0] rx_count, tx_count;
    ictl_t            ictl, ictl_nx;
    logic             unused_addr_hi;

    assign off            = reg_addr[5:0];
    assign unused_addr_hi = ^reg_addr;
    assign host_wr        = reg_wr;
    assign host_rd        = reg_rd && !reg_wr;
    assign soft_rst       = host_wr && (off == OFF_ICTL) && !reg_wdata[ICTL_TXD]
                          && !reg_wdata[ICTL_RXD] && reg_wdata[ICTL_TEST];
    assign irq            = ictl.test || ictl.rxd || ictl.txd;

    nic_rx_capture #(.MAX_FRAME(MAX_FRAME)) u_rx (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .can_start(!busy),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .pop(host_rd && off == OFF_RXDATA), .pop_data(pop_data),
        .rx_count(rx_count), .frame_done(rx_done)
    );

    nic_tx_path #(.MAX_FRAME(MAX_FRAME)) u_tx (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .cnt_wr(host_wr && off == OFF_TXCNT), .cnt_val(reg_wdata),
        .dat_wr(host_wr && off == OFF_TXDATA), .dat_byte(reg_wdata[7:0]),
        .tx_count(tx_count), .sent(tx_sent),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    always_comb begin
        ictl_nx = ictl;
        busy_nx = busy;
        if (host_rd && off == OFF_ICTL) ictl_nx.test = 1'b0;
        if (host_wr && off == OFF_ICTL) begin
            if (reg_wdata[ICTL_TXD])       ictl_nx.txd = 1'b0;
            else if (reg_wdata[ICTL_RXD])  ictl_nx.rxd = 1'b0;
            else if (reg_wdata[ICTL_TEST]) ictl_nx = '{test: 1'b1, rxd: 1'b0, txd: 1'b0};
            busy_nx = ictl_nx.test || ictl_nx.rxd || ictl_nx.txd;
        end
        if (tx_sent) begin
            ictl_nx.txd = 1'b1;
            busy_nx     = 1'b1;
        end
        if (rx_done) begin
            ictl_nx.rxd = 1'b1;
            busy_nx     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ictl <= '0;
            busy <= 1'b1;
        end else begin
            ictl <= ictl_nx;
            busy <= busy_nx;
        end
    end

    always_comb begin
        case (off)
            OFF_ID0:    reg_rdata = ID_WORD0;
            OFF_ID1:    reg_rdata = ID_WORD1;
            OFF_BUSY:   reg_rdata = {31'd0, busy};
            OFF_RXCNT:  reg_rdata = 32'(rx_count);
            OFF_TXCNT:  reg_rdata = 32'(tx_count);
            OFF_ICTL:   reg_rdata = ictl_word(ictl);
            OFF_RXDATA: reg_rdata = {24'd0, pop_data};
            default:    reg_rdata = 32'd0;
        endcase
    end

    // R10
    irq_implies_busy_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> busy);

    // R8
    test_clr_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        (host_rd && off == OFF_ICTL) |=> !ictl.test);

    // R11
    self_test_state_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (rx_count == '0 && tx_count == '0 && ictl.test && !ictl.rxd && !ictl.txd));

endmodule

// File: tb/test_nic_regport.sv
`timescale 1ns/1ps
module test_nic_regport;
    localparam int          MAXF = 16;
    localparam logic [31:0] ID0  = 32'h4E49_4330;
    localparam logic [31:0] ID1  = 32'h5042_5546;

    logic        clk = 1'b0, rst = 1'b1;
    logic [7:0]  reg_addr = '0;
    logic        reg_rd = 1'b0, reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq, rx_valid = 1'b0, rx_last = 1'b0, rx_ready;
    logic [7:0]  rx_data = '0, tx_data;
    logic        tx_valid, tx_last, tx_ready = 1'b0;

    int tests = 0, fails = 0;
    logic [7:0] fbuf [32];
    logic [7:0] got  [32];
    int got_n, got_last;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    nic_regport #(.ADDR_W(8), .MAX_FRAME(MAXF), .ID_WORD0(ID0), .ID_WORD1(ID1)) i_nic_regport (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    function automatic int exp_rx_len(int len);
        return (len > MAXF) ? MAXF : len;
    endfunction

    function automatic int exp_tx_cnt(int v);
        return (v <= MAXF) ? v : 0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic push_frame(int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = fbuf[i]; rx_last = (i == len - 1);
            @(posedge clk); #1;
        end
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic fill_rand(int len);
        for (int i = 0; i < len; i++) fbuf[i] = 8'($urandom);
    endtask

    task automatic collect();
        got_n = 0; got_last = -1;
        for (int c = 0; c < 2000; c++) begin
            @(negedge clk);
            tx_ready = ($urandom % 3) != 0;
            #1;
            if (tx_valid && tx_ready) begin
                got[got_n] = tx_data;
                if (tx_last) got_last = got_n;
                got_n++;
            end
            @(posedge clk); #1;
            if (got_last >= 0) break;
        end
        tx_ready = 1'b0;
    endtask

    task automatic clear_busy();
        wr(8'h14, 32'h1);
        wr(8'h14, 32'h2);
    endtask

    task automatic send_tx(int len);
        wr(8'h10, len);
        for (int i = 0; i < len; i++) wr(8'h20, {24'h0, fbuf[i]});
    endtask

    initial begin
        #(5.0 * 150000);
        fails++; tests++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R3 reset state
        rd(8'h08, rv); chk("R3 busy", rv, 1);
        rd(8'h0C, rv); chk("R3 rxcnt", rv, 0);
        rd(8'h10, rv); chk("R3 txcnt", rv, 0);
        rd(8'h14, rv); chk("R3 ictl", rv, 0);
        chk("R3 irq", irq, 0);
        // R2 constants and zero reads
        rd(8'h00, rv); chk("R2 id0", rv, ID0);
        rd(8'h04, rv); chk("R2 id1", rv, ID1);
        rd(8'h18, rv); chk("R2 iinfo", rv, 0);
        rd(8'h20, rv); chk("R2 txdata read", rv, 0);
        rd(8'h3C, rv); chk("R2 unmapped", rv, 0);
        // R1 alias through upper address bits
        rd(8'hC4, rv); chk("R1 alias id1", rv, ID1);
        rd(8'h48, rv); chk("R1 alias busy", rv, 1);
        // R2 writes to read-only registers ignored
        wr(8'h08, 32'h0); rd(8'h08, rv); chk("R2 busy ro", rv, 1);
        wr(8'h0C, 32'h7); rd(8'h0C, rv); chk("R2 rxcnt ro", rv, 0);
        wr(8'h00, 32'h0); rd(8'h00, rv); chk("R2 id ro", rv, ID0);

        // R5 frame while busy is dropped
        chk("R5 ready low while busy", rx_ready, 0);
        fill_rand(4); push_frame(4);
        rd(8'h0C, rv); chk("R5 dropped rxcnt", rv, 0);
        rd(8'h14, rv); chk("R5 dropped ictl", rv, 0);

        // R10 zero write: busy follows ictl
        wr(8'h14, 32'h0);
        rd(8'h08, rv); chk("R10 busy after zero write", rv, 0);
        chk("R5 ready when idle", rx_ready, 1);

        // R6 oversize frame truncated
        fill_rand(20); push_frame(20);
        rd(8'h0C, rv); chk("R6 capped count", rv, MAXF);
        rd(8'h14, rv); chk("R6 rxdone", rv, 32'h2);
        chk("R4 irq on rxdone", irq, 1);
        rd(8'h08, rv); chk("R6 busy", rv, 1);
        chk("R5 ready low after accept", rx_ready, 0);
        for (int i = 0; i < MAXF; i++) begin
            rd(8'h1C, rv); chk("R7 byte", rv, {24'h0, fbuf[i]});
        end
        rd(8'h1C, rv); chk("R7 empty read", rv, 0);
        rd(8'h0C, rv); chk("R7 count stays 0", rv, 0);

        // R9 count clamp
        wr(8'h10, MAXF + 1); rd(8'h10, rv); chk("R9 over max", rv, 0);
        wr(8'h10, MAXF);     rd(8'h10, rv); chk("R9 at max", rv, MAXF);

        // random rx/tx rounds
        for (int it = 0; it < 8; it++) begin
            int rl, tl;
            clear_busy();
            rd(8'h08, rv); chk("R10 busy cleared", rv, 0);
            rl = 1 + ($urandom % 20);
            fill_rand(rl); push_frame(rl);
            rd(8'h0C, rv); chk("R6 rx len", rv, exp_rx_len(rl));
            for (int i = 0; i < exp_rx_len(rl); i++) begin
                rd(8'h1C, rv); chk("R7 rand byte", rv, {24'h0, fbuf[i]});
            end
            tl = 1 + ($urandom % MAXF);
            fill_rand(tl); send_tx(tl);
            rd(8'h10, rv); chk("R12 txcnt cleared", rv, 0);
            rd(8'h14, rv); chk("R12 txdone set", rv[0], 1);
            collect();
            chk("R12 frame length", got_n, tl);
            chk("R12 last position", got_last, tl - 1);
            for (int i = 0; i < tl; i++) chk("R12 tx byte", got[i], fbuf[i]);
        end

        // R13 writes during drain ignored
        clear_busy();
        fill_rand(5); send_tx(5);
        wr(8'h10, 32'h1);
        wr(8'h20, 32'hAA);
        collect();
        chk("R13 drained frame length", got_n, 5);
        for (int i = 0; i < 5; i++) chk("R13 drained byte", got[i], fbuf[i]);
        repeat (3) @(posedge clk); #1;
        chk("R13 no second frame", tx_valid, 0);
        rd(8'h10, rv); chk("R13 count kept", rv, 1);
        wr(8'h20, 32'h55);
        collect();
        chk("R12 single byte len", got_n, 1);
        chk("R12 single byte", got[0], 8'h55);
        chk("R12 single last", got_last, 0);

        // R10 priority: both done bits set
        clear_busy();
        fill_rand(3); push_frame(3);
        fbuf[0] = 8'h11; send_tx(1); collect();
        rd(8'h14, rv); chk("R4 both bits", rv, 32'h3);
        wr(8'h14, 32'h8000_0002);
        rd(8'h14, rv); chk("R10 rx cleared first", rv, 32'h1);
        rd(8'h0C, rv); chk("R10 no reset", rv, 3);
        wr(8'h14, 32'h3);
        rd(8'h14, rv); chk("R10 tx cleared", rv, 0);
        rd(8'h08, rv); chk("R10 busy low", rv, 0);
        chk("R4 irq low", irq, 0);

        // R11 self-test
        wr(8'h10, 32'h5);
        wr(8'h14, 32'h8000_0000);
        chk("R4 irq on test", irq, 1);
        rd(8'h14, rv); chk("R11 test bit", rv, 32'h8000_0000);
        rd(8'h14, rv); chk("R8 cleared on read", rv, 0);
        chk("R8 irq low", irq, 0);
        rd(8'h0C, rv); chk("R11 rxcnt", rv, 0);
        rd(8'h10, rv); chk("R11 txcnt", rv, 0);
        rd(8'h08, rv); chk("R11 busy", rv, 1);
        wr(8'h14, 32'h0);
        rd(8'h08, rv); chk("R10 busy after ack", rv, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule